// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Pin Cells

This block is a serial test access port driven by a test clock, a mode-select line and a serial data input. It holds an instruction register and three data registers: a one-bit bypass stage, a 32-bit identification register and a boundary register. The boundary register has one cell for each input pin and a group of three cells for each output pin. These cells let a tester read the pins and core signals. Under the external-test instruction, the tester can also drive the output pins and their enables in place of the core logic.

There is no separate test-reset pin. The port returns to its reset state through the synchronous power-up reset `por`, or when the mode-select line is held high for five test-clock cycles. The serial output changes on the falling test-clock edge. A companion enable output marks the cycles in which the serial output should drive its pad; in all other cycles the pad is left floating.

Top module: `tap_bscan`

## Requirements
- R1: While `por` is high at a rising `tck`, the port enters Test-Logic-Reset, the instruction becomes IDCODE, all update stages clear to 0, and at the next falling `tck` both `tdo_oe` and `tdo` become 0.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the instruction becomes IDCODE.
- R3: The instruction register is 4 bits wide. The codes are EXTEST = 0000, SAMPLE/PRELOAD = 0001, IDCODE = 0010 and BYPASS = 1111, and any other code behaves as BYPASS. Capture-IR loads 0001, Shift-IR shifts out LSB first, and the new code takes effect at the edge that leaves Update-IR.
- R4: Under IDCODE, Capture-DR loads the 32-bit `IDCODE_VAL` with bit 0 forced to 1, and Shift-DR shifts it out LSB first.
- R5: Under BYPASS, the data path is a single stage that captures 0, so `tdo` repeats `tdi` one shift cycle later.
- R6: The boundary register has 3*N_OUT+N_IN bits, and bit 0 is nearest to `tdo`. For output pin k, bit 3k captures `pad_in[k]`, bit 3k+1 captures `core_out[k]` and bit 3k+2 captures `core_oe[k]`. Bit 3*N_OUT+j captures `pin_in[j]`. Capture happens in Capture-DR under SAMPLE/PRELOAD or EXTEST.
- R7: The update stages of output pin k load bits 3k+1 and 3k+2 only at the edge that leaves Update-DR, and only under SAMPLE/PRELOAD or EXTEST. At all other times they hold, including during Shift-DR.
- R8: Under EXTEST, `pad_out`/`pad_oe` come from the update stages. Under any other instruction they equal `core_out`/`core_oe`.
- R9: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-up reset, active high, synchronous to `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for the `tdo` pad |
| core_out | input | N_OUT | Core output values |
| core_oe | input | N_OUT | Core output enables |
| pad_in | input | N_OUT | Values seen at the output pins |
| pin_in | input | N_IN | Values of the input-only pins |
| pad_out | output | N_OUT | Value driven to each output pin |
| pad_oe | output | N_OUT | Enable of each output pin driver |

## Verification
Two things can change the pads at the same rising edge: the instruction switching at the exit from Update-IR, and a reset by five high `tms` cycles. Leaving Update-IR into EXTEST must make the pads take the preloaded update values at that very edge. Likewise, a `tms` reset taken during EXTEST must return the pads to the core values at the same edge that restores IDCODE. The bench provokes both by preloading under SAMPLE/PRELOAD, loading EXTEST, changing the core values, and finally walking `tms` high. A behavioural model compares the pads and `tdo` on every clock, so a switch one edge late or one edge early is reported.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] ir_code_t;

    localparam ir_code_t IR_EXTEST  = '0;
    localparam ir_code_t IR_SAMPLE  = IR_W'(1);
    localparam ir_code_t IR_IDCODE  = IR_W'(2);
    localparam ir_code_t IR_BYPASS  = {IR_W{1'b1}};
    localparam ir_code_t IR_CAPTURE = IR_W'(1);

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BOUNDARY} dr_sel_e;

    typedef struct packed {
        logic    extest;
        dr_sel_e sel;
    } ir_dec_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            TLR:     return tms ? TLR    : RTI;
            RTI:     return tms ? SEL_DR : RTI;
            SEL_DR:  return tms ? SEL_IR : CAP_DR;
            CAP_DR:  return tms ? EX1_DR : SH_DR;
            SH_DR:   return tms ? EX1_DR : SH_DR;
            EX1_DR:  return tms ? UPD_DR : PAU_DR;
            PAU_DR:  return tms ? EX2_DR : PAU_DR;
            EX2_DR:  return tms ? UPD_DR : SH_DR;
            UPD_DR:  return tms ? SEL_DR : RTI;
            SEL_IR:  return tms ? TLR    : CAP_IR;
            CAP_IR:  return tms ? EX1_IR : SH_IR;
            SH_IR:   return tms ? EX1_IR : SH_IR;
            EX1_IR:  return tms ? UPD_IR : PAU_IR;
            PAU_IR:  return tms ? EX2_IR : PAU_IR;
            EX2_IR:  return tms ? UPD_IR : SH_IR;
            UPD_IR:  return tms ? SEL_DR : RTI;
            default: return TLR;
        endcase
    endfunction

    function automatic ir_dec_t ir_decode(ir_code_t c);
        ir_dec_t d;
        d.extest = 1'b0;
        d.sel    = DR_BYPASS;
        case (c)
            IR_EXTEST: begin d.extest = 1'b1; d.sel = DR_BOUNDARY; end
            IR_SAMPLE: d.sel = DR_BOUNDARY;
            IR_IDCODE: d.sel = DR_IDCODE;
            default:   d.sel = DR_BYPASS;
        endcase
        return d;
    endfunction

    function automatic logic in_shift(tap_state_e s);
        return (s == SH_DR) || (s == SH_IR);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (por) state <= TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  tap_state_e state,
    input  logic       tdi,
    output ir_code_t   ir_q,
    output logic       ir_so
);
    ir_code_t sh;

    always_ff @(posedge tck) begin
        if (por)                  sh <= '0;
        else if (state == CAP_IR) sh <= IR_CAPTURE;
        else if (state == SH_IR)  sh <= {tdi, sh[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (por || state == TLR)  ir_q <= IR_IDCODE;
        else if (state == UPD_IR) ir_q <= sh;
    end

    assign ir_so = sh[0];
endmodule

// File: rtl/bs_out_cell.sv
module bs_out_cell (
    input  logic tck,
    input  logic por,
    input  logic cap_en,
    input  logic sh_en,
    input  logic upd_en,
    input  logic extest,
    input  logic si,
    input  logic core_out,
    input  logic core_oe,
    input  logic pad_in,
    output logic so,
    output logic pad_out,
    output logic pad_oe
);
    logic c_oe, c_out, c_pin;
    logic u_out, u_oe;

    always_ff @(posedge tck) begin
        if (por)         {c_oe, c_out, c_pin} <= 3'b000;
        else if (cap_en) {c_oe, c_out, c_pin} <= {core_oe, core_out, pad_in};
        else if (sh_en)  {c_oe, c_out, c_pin} <= {si, c_oe, c_out};
    end

    always_ff @(posedge tck) begin
        if (por) begin
            u_out <= 1'b0;
            u_oe  <= 1'b0;
        end else if (upd_en) begin
            u_out <= c_out;
            u_oe  <= c_oe;
        end
    end

    assign so      = c_pin;
    assign pad_out = extest ? u_out : core_out;
    assign pad_oe  = extest ? u_oe  : core_oe;
endmodule

// File: rtl/bs_in_cell.sv
module bs_in_cell (
    input  logic tck,
    input  logic por,
    input  logic cap_en,
    input  logic sh_en,
    input  logic si,
    input  logic pin,
    output logic so
);
    always_ff @(posedge tck) begin
        if (por)         so <= 1'b0;
        else if (cap_en) so <= pin;
        else if (sh_en)  so <= si;
    end
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
    import tap_pkg::*;
#(
    parameter int          N_OUT      = 4,
    parameter int          N_IN       = 2,
    parameter logic [31:0] IDCODE_VAL = 32'h1A5B_C0DF
) (
    input  logic             tck,
    input  logic             por,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    input  logic [N_OUT-1:0] pad_in,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);
    localparam int BSR_LEN = 3 * N_OUT + N_IN;
    localparam int ID_W    = 32;

    tap_state_e       st;
    ir_code_t         ir_q;
    logic             ir_so;
    ir_dec_t          dec;
    logic             bsr_sel;
    logic             bs_cap, bs_sh, bs_upd;
    logic [BSR_LEN:0] lnk;
    logic             by_q;
    logic [ID_W-1:0]  id_sh;
    logic             dr_so;

    tap_fsm u_fsm (.tck(tck), .por(por), .tms(tms), .state(st));

    tap_ir u_ir (.tck(tck), .por(por), .state(st), .tdi(tdi),
                 .ir_q(ir_q), .ir_so(ir_so));

    assign dec     = ir_decode(ir_q);
    assign bsr_sel = (dec.sel == DR_BOUNDARY);
    assign bs_cap  = bsr_sel && (st == CAP_DR);
    assign bs_sh   = bsr_sel && (st == SH_DR);
    assign bs_upd  = bsr_sel && (st == UPD_DR);

    assign lnk[BSR_LEN] = tdi;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        bs_out_cell u_cell (
            .tck(tck), .por(por), .cap_en(bs_cap), .sh_en(bs_sh),
            .upd_en(bs_upd), .extest(dec.extest), .si(lnk[3*k+3]),
            .core_out(core_out[k]), .core_oe(core_oe[k]), .pad_in(pad_in[k]),
            .so(lnk[3*k]), .pad_out(pad_out[k]), .pad_oe(pad_oe[k])
        );
        assign lnk[3*k+1] = 1'b0;
        assign lnk[3*k+2] = 1'b0;
    end

    for (genvar j = 0; j < N_IN; j++) begin : g_in
        bs_in_cell u_cell (
            .tck(tck), .por(por), .cap_en(bs_cap), .sh_en(bs_sh),
            .si(lnk[3*N_OUT+j+1]), .pin(pin_in[j]), .so(lnk[3*N_OUT+j])
        );
    end

    always_ff @(posedge tck) begin
        if (por) begin
            by_q  <= 1'b0;
            id_sh <= '0;
        end else begin
            if (dec.sel == DR_BYPASS) begin
                if (st == CAP_DR)     by_q <= 1'b0;
                else if (st == SH_DR) by_q <= tdi;
            end
            if (dec.sel == DR_IDCODE) begin
                if (st == CAP_DR)     id_sh <= IDCODE_VAL | ID_W'(1);
                else if (st == SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
        end
    end

    always_comb begin
        case (dec.sel)
            DR_IDCODE:   dr_so = id_sh[0];
            DR_BOUNDARY: dr_so = lnk[0];
            default:     dr_so = by_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (por) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift(st);
            if (st == SH_IR)      tdo <= ir_so;
            else if (st == SH_DR) tdo <= dr_so;
        end
    end
endmodule

// File: rtl/tap_bscan_chk.sv
module tap_bscan_chk
    import tap_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input logic             tck,
    input logic             por,
    input logic             tms,
    input logic             tdo_oe,
    input tap_state_e       st,
    input ir_code_t         ir_q,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe
);
    // R2
    tms_reset_chk: assert property (@(posedge tck) disable iff (por)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (st == TLR));

    // R1
    ir_default_chk: assert property (@(posedge tck) disable iff (por)
        $past(st == TLR) |-> (ir_q == IR_IDCODE));

    // R9
    tdo_enable_chk: assert property (@(posedge tck) disable iff (por)
        tdo_oe == in_shift(st));

    // R8
    core_pass_chk: assert property (@(posedge tck) disable iff (por)
        (ir_q != IR_EXTEST) |-> (pad_out == core_out && pad_oe == core_oe));

    // R7
    update_hold_chk: assert property (@(posedge tck) disable iff (por)
        (ir_q == IR_EXTEST && $past(ir_q) == IR_EXTEST && $past(st) != UPD_DR && !$past(por))
        |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind tap_bscan tap_bscan_chk #(.N_OUT(N_OUT)) u_chk (
    .tck(tck), .por(por), .tms(tms), .tdo_oe(tdo_oe), .st(st), .ir_q(ir_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_out(core_out), .core_oe(core_oe)
);

// File: tb/sim_tap_bscan.sv
`timescale 1ns/1ps
module sim_tap_bscan;
    import tap_pkg::*;

    localparam int          NO  = 4;
    localparam int          NI  = 2;
    localparam int          LEN = 3 * NO + NI;
    localparam logic [31:0] IDV = 32'h1A5B_C0DF;

    logic tck = 0, por = 1, tms = 1, tdi = 0;
    logic tdo, tdo_oe;
    logic [NO-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] pad_out, pad_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 tck = ~tck;

    tap_bscan #(.N_OUT(NO), .N_IN(NI), .IDCODE_VAL(IDV)) u0 (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference model
    tap_state_e ms;
    int         mir;
    bit         dq[$];
    bit         iq[$];
    bit [NO-1:0] m_uo, m_ue;
    bit         mtdo, mtdo_oe;

    function automatic tap_state_e mnext(tap_state_e s, logic t);
        case (s)
            TLR:    return t ? TLR : RTI;
            RTI:    return t ? SEL_DR : RTI;
            SEL_DR: return t ? SEL_IR : CAP_DR;
            SEL_IR: return t ? TLR : CAP_IR;
            CAP_DR, SH_DR: return t ? EX1_DR : SH_DR;
            CAP_IR, SH_IR: return t ? EX1_IR : SH_IR;
            EX1_DR: return t ? UPD_DR : PAU_DR;
            EX1_IR: return t ? UPD_IR : PAU_IR;
            PAU_DR: return t ? EX2_DR : PAU_DR;
            PAU_IR: return t ? EX2_IR : PAU_IR;
            EX2_DR: return t ? UPD_DR : SH_DR;
            EX2_IR: return t ? UPD_IR : SH_IR;
            default: return t ? SEL_DR : RTI;
        endcase
    endfunction

    function automatic bit m_bsr();
        return mir == 0 || mir == 1;
    endfunction

    always @(posedge tck) begin
        if (por) begin
            ms = TLR; mir = 2; m_uo = '0; m_ue = '0;
        end else begin
            case (ms)
                CAP_IR: iq = '{1, 0, 0, 0};
                SH_IR:  begin void'(iq.pop_front()); iq.push_back(tdi); end
                UPD_IR: begin mir = 0; for (int i = 0; i < 4; i++) mir += int'(iq[i]) << i; end
                CAP_DR: begin
                    dq.delete();
                    if (mir == 2) for (int i = 0; i < 32; i++) dq.push_back(i == 0 ? 1'b1 : IDV[i]);
                    else if (m_bsr()) begin
                        for (int k = 0; k < NO; k++) begin
                            dq.push_back(pad_in[k]); dq.push_back(core_out[k]); dq.push_back(core_oe[k]);
                        end
                        for (int j = 0; j < NI; j++) dq.push_back(pin_in[j]);
                    end else dq.push_back(1'b0);
                end
                SH_DR:  begin void'(dq.pop_front()); dq.push_back(tdi); end
                UPD_DR: if (m_bsr()) for (int k = 0; k < NO; k++) begin
                            m_uo[k] = dq[3*k+1]; m_ue[k] = dq[3*k+2];
                        end
                default: ;
            endcase
            if (ms == TLR) mir = 2;
            ms = mnext(ms, tms);
        end
    end

    always @(negedge tck) begin
        if (por) begin mtdo = 0; mtdo_oe = 0; end
        else begin
            mtdo_oe = (ms == SH_DR) || (ms == SH_IR);
            if (ms == SH_IR) mtdo = iq[0];
            else if (ms == SH_DR) mtdo = dq[0];
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison with the model
    always @(posedge tck) begin
        #1.25;
        if (!por && !done) begin
            chk("R9 tdo_oe", 64'(tdo_oe), 64'(mtdo_oe));
            if (mtdo_oe) chk("R9 tdo", 64'(tdo), 64'(mtdo));
            chk("R8 pad_out", 64'(pad_out), 64'(mir == 0 ? m_uo : core_out));
            chk("R8 pad_oe",  64'(pad_oe),  64'(mir == 0 ? m_ue : core_oe));
        end
    end

    task automatic step(input bit t, input bit d, output bit o);
        @(negedge tck); #0.5;
        o = tdo; tms = t; tdi = d;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        bit o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin step(i == n - 1, din[i], o); dout[i] = o; end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        bit o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) begin step(i == 3, code[i], o); cap[i] = o; end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic idle(int n);
        bit o;
        for (int i = 0; i < n; i++) step(0, 0, o);
    endtask

    function automatic logic [63:0] exp_cap();
        logic [63:0] v = '0;
        for (int k = 0; k < NO; k++) begin
            v[3*k] = pad_in[k]; v[3*k+1] = core_out[k]; v[3*k+2] = core_oe[k];
        end
        for (int j = 0; j < NI; j++) v[3*NO+j] = pin_in[j];
        return v;
    endfunction

    function automatic logic [2*NO-1:0] exp_upd(logic [63:0] p);
        logic [2*NO-1:0] r;
        for (int k = 0; k < NO; k++) begin r[k] = p[3*k+1]; r[NO+k] = p[3*k+2]; end
        return r;
    endfunction

    initial begin
        logic [63:0] d;
        logic [3:0]  ic;
        logic [63:0] pre;
        bit o;
        repeat (3) @(negedge tck);
        #0.5; por = 0; tms = 0;
        idle(1);
        // R1: reset state seen at the ports
        chk("R1 tdo_oe after reset", 64'(tdo_oe), 64'd0);
        chk("R1 pads follow core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
        // R1 R4: IDCODE is the default instruction
        scan_dr(32, 64'hFFFF_0000, d);
        chk("R4 idcode", d[31:0], 64'(IDV | 32'h1));
        // R3 R5: bypass
        scan_ir(IR_BYPASS, ic);
        chk("R3 ir capture", 64'(ic), 64'h1);
        scan_dr(8, 64'hA5, d);
        chk("R5 bypass delay", d[7:0], 64'h4A);
        // R3: unknown code acts as bypass
        scan_ir(4'b0110, ic);
        scan_dr(6, 64'h2D, d);
        chk("R3 unknown code bypass", d[5:0], 64'h1A);
        // R6: sample/preload
        core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b1100; pin_in = 2'b01;
        scan_ir(IR_SAMPLE, ic);
        pre = 64'h2B6D;
        scan_dr(LEN, pre, d);
        chk("R6 sample capture", d[LEN-1:0], exp_cap() & ((64'd1 << LEN) - 1));
        idle(1);
        chk("R8 sample keeps core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
        // R8 R3: EXTEST drives preloaded values from the Update-IR exit edge
        scan_ir(IR_EXTEST, ic);
        idle(1);
        chk("R8 extest drives update", 64'({pad_oe, pad_out}), 64'(exp_upd(pre)));
        // R7: core changes and shifting do not move the pads
        core_out = 4'b0101; core_oe = 4'b1001;
        idle(2);
        chk("R7 hold vs core", 64'({pad_oe, pad_out}), 64'(exp_upd(pre)));
        pad_in = 4'b0011;
        scan_dr(LEN, 64'h1C53, d);
        chk("R6 extest capture", d[LEN-1:0], exp_cap() & ((64'd1 << LEN) - 1));
        idle(1);
        chk("R7 new update", 64'({pad_oe, pad_out}), 64'(exp_upd(64'h1C53)));
        // R2: five TMS high cycles restore IDCODE and core drive
        for (int i = 0; i < 5; i++) step(1, 0, o);
        idle(1);
        chk("R2 pads back to core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
        scan_dr(32, 64'h0, d);
        chk("R2 idcode after tms reset", d[31:0], 64'(IDV | 32'h1));
        idle(2);
        chk("R9 tdo_oe idle", 64'(tdo_oe), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule